// File: doc/BRIEF.md
# Signed Q8.24 Sequential Divider

This block divides one signed fixed-point number by another. Both operands and the result are 32-bit two's-complement values with 8 integer bits and 24 fraction bits. A single-cycle start request captures the operands. The block then works through a restoring shift-subtract loop that resolves one quotient bit per clock. When the loop ends, it presents the quotient with a one-cycle completion pulse.

The division is carried out on magnitudes. The result sign is taken as the XOR of the operand signs, and the quotient is negated in the last cycle when that sign is negative. The dividend is treated as scaled by 2^24, so the loop runs 24 extra steps whose quotient bits fall off the top of the 32-bit result. The quotient is truncated toward zero. A result too large for the format wraps to its low 32 bits without any flag. A zero divisor skips the loop and returns a saturated value.

Top module: `sfx_divider`

## Requirements
- R1: After synchronous reset, busy_o, done_o and dbz_o are 0 and quotient_o is 0.
- R2: For a non-zero divisor, quotient_o equals the low 32 bits of (dividend × 2^24) / divisor, with both operands read as signed Q8.24 (bit 31 is the sign, bits 23:0 the fraction).
- R3: The result is negative exactly when one operand is negative and the quotient is non-zero. This holds for every operand sign, including the most negative value 0x80000000.
- R4: The quotient is truncated toward zero. For example, 1.0/3.0 gives 0x00555555 and -1.0/3.0 gives 0xFFAAAAAB.
- R5: busy_o rises on the clock edge that samples start_i high while idle. For a non-zero divisor, done_o rises on the 57th rising edge after that capturing edge (DATA_W+FRAC_W+1). done_o stays high for exactly one cycle, and busy_o is 0 while done_o is high.
- R6: A start_i pulse while busy_o is high is ignored. The running operation ends at its normal time with the quotient of its original operands.
- R7: A zero divisor makes done_o rise on the first edge after the capturing edge, with dbz_o = 1. quotient_o is then 0x7FFFFFFF for a dividend with bit 31 clear and 0x80000000 for a dividend with bit 31 set.
- R8: When the quotient magnitude is 2^31 or more, the result is the low 32 bits of the exact truncated quotient, and dbz_o stays 0.
- R9: quotient_o and dbz_o change only on the edge that raises done_o, and they hold their values through idle cycles until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to capture the operands and begin |
| dividend_i | input | 32 | Signed Q8.24 dividend |
| divisor_i | input | 32 | Signed Q8.24 divisor |
| busy_o | output | 1 | High from capture until the result is presented |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| dbz_o | output | 1 | Divisor was zero for the latest result |
| quotient_o | output | 32 | Signed Q8.24 quotient, held until the next completion |

## Verification
The operand patterns are chosen to separate different faults:
- Integer-valued operands with exact quotients confirm the 24-bit scaling and the discarding of early quotient bits.
- A sweep over all four sign combinations, including 0x80000000, separates a wrong sign XOR or a faulty magnitude conversion from a loop error.
- Inexact ratios such as ±1/3 expose any rounding in place of truncation toward zero.
- Divisors near 2^-24, together with quotients of exactly 2^31 and 2^32, show silent wrapping.
- Zero divisors with each dividend sign tell the two saturation values apart.
- Random operands with divisors of widely varying magnitude cover the restore and subtract decisions in general.

// File: rtl/sfx_div_pkg.sv
package sfx_div_pkg;
  parameter int DEF_DATA_W = 32;
  parameter int DEF_FRAC_W = 24;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIN  = 2'd2
  } div_state_e;
endpackage

// File: rtl/sfx_div_signmag.sv
// Converts two signed operands to unsigned magnitudes and derives sign facts.
module sfx_div_signmag #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] num_i,
  input  logic [DATA_W-1:0] den_i,
  output logic [DATA_W-1:0] num_mag_o,
  output logic [DATA_W-1:0] den_mag_o,
  output logic              res_neg_o,
  output logic              num_neg_o,
  output logic              den_zero_o
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    num_mag_o  = num_i[MSB] ? (~num_i + 1'b1) : num_i;
    den_mag_o  = den_i[MSB] ? (~den_i + 1'b1) : den_i;
    res_neg_o  = num_i[MSB] ^ den_i[MSB];
    num_neg_o  = num_i[MSB];
    den_zero_o = (den_i == '0);
  end
endmodule

// File: rtl/sfx_div_step.sv
// One restoring shift-subtract step on unsigned magnitudes.
module sfx_div_step #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rem_i,
  input  logic              bit_i,
  input  logic [DATA_W-1:0] den_i,
  output logic [DATA_W-1:0] rem_o,
  output logic              qbit_o
);
  logic [DATA_W:0]   shifted;
  logic [DATA_W-1:0] diff;

  always_comb begin
    shifted = {rem_i, bit_i};
    // Only used when the subtraction fits, so the truncated width is exact.
    diff    = shifted[DATA_W-1:0] - den_i;
    qbit_o  = (shifted >= {1'b0, den_i});
    rem_o   = qbit_o ? diff : shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/sfx_divider.sv
module sfx_divider
  import sfx_div_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              dbz_o,
  output logic [DATA_W-1:0] quotient_o
);
  localparam int ITERS = DATA_W + FRAC_W;
  localparam int CNT_W = $clog2(ITERS);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(ITERS - 1);
  localparam logic [DATA_W-1:0] POS_SAT  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_SAT  = {1'b1, {(DATA_W-1){1'b0}}};

  div_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] num_q;   // dividend magnitude, zeros shift in behind it
  logic [DATA_W-1:0] den_q;
  logic [DATA_W-1:0] rem_q;
  logic [DATA_W-1:0] quo_q;   // early bits drop off the top
  logic              neg_q;
  logic              dz_pend_q;
  logic              busy_q, done_q, dbz_q;
  logic [DATA_W-1:0] res_q;

  logic [DATA_W-1:0] mag_a, mag_b, rem_nx;
  logic              res_neg, a_neg, b_zero, qbit;

  sfx_div_signmag #(.DATA_W(DATA_W)) u_signmag (
    .num_i      (dividend_i),
    .den_i      (divisor_i),
    .num_mag_o  (mag_a),
    .den_mag_o  (mag_b),
    .res_neg_o  (res_neg),
    .num_neg_o  (a_neg),
    .den_zero_o (b_zero)
  );

  sfx_div_step #(.DATA_W(DATA_W)) u_step (
    .rem_i  (rem_q),
    .bit_i  (num_q[DATA_W-1]),
    .den_i  (den_q),
    .rem_o  (rem_nx),
    .qbit_o (qbit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      num_q     <= '0;
      den_q     <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      neg_q     <= 1'b0;
      dz_pend_q <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      dbz_q     <= 1'b0;
      res_q     <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start_i) begin
            busy_q    <= 1'b1;
            num_q     <= mag_a;
            den_q     <= mag_b;
            rem_q     <= '0;
            cnt_q     <= CNT_LAST;
            dz_pend_q <= b_zero;
            if (b_zero) begin
              quo_q <= a_neg ? NEG_SAT : POS_SAT;
              neg_q <= 1'b0;
              st_q  <= S_FIN;
            end else begin
              quo_q <= '0;
              neg_q <= res_neg;
              st_q  <= S_RUN;
            end
          end
        end
        S_RUN: begin
          num_q <= {num_q[DATA_W-2:0], 1'b0};
          rem_q <= rem_nx;
          quo_q <= {quo_q[DATA_W-2:0], qbit};
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == '0) st_q <= S_FIN;
        end
        S_FIN: begin
          res_q  <= neg_q ? (~quo_q + 1'b1) : quo_q;
          dbz_q  <= dz_pend_q;
          done_q <= 1'b1;
          busy_q <= 1'b0;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign dbz_o      = dbz_q;
  assign quotient_o = res_q;

  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5: never busy and done together
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R5: an accepted start raises busy on the next cycle
  a_r5_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  // R5: the loop keeps the block busy
  a_r5_run_busy: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_RUN) |-> busy_o);

  // R6: a start during an operation leaves the captured operands alone
  a_r6_ignore_start: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> ($stable(den_q) && $stable(neg_q)));

  // R7: divide by zero yields one of the two saturation values
  a_r7_dbz_sat: assert property (@(posedge clk) disable iff (rst)
    (done_o && dbz_o) |-> (quotient_o == POS_SAT || quotient_o == NEG_SAT));

  // R9: result outputs move only with the completion pulse
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!done_o && $past(!rst)) |=> (done_o || ($stable(quotient_o) && $stable(dbz_o))));
endmodule

// File: tb/sfx_divider_bench.sv
`timescale 1ns/1ps
module sfx_divider_bench;
  localparam int ITERS   = 56;
  localparam int LAT_RUN = ITERS + 2;  // negedges from start-drive to visible done
  localparam int LAT_DBZ = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] dividend, divisor;
  logic        busy, done, dbz;
  logic [31:0] quotient;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sfx_divider u_sfx_divider (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .dividend_i (dividend),
    .divisor_i  (divisor),
    .busy_o     (busy),
    .done_o     (done),
    .dbz_o      (dbz),
    .quotient_o (quotient)
  );

  function automatic logic [31:0] ref_quot(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] n, d, q;
    n = {{32{a[31]}}, a} <<< 24;
    d = {{32{b[31]}}, b};
    q = n / d;
    return q[31:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Launch one operation; optionally poke a second start while running.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input int poke,
                        output int lat, output logic busy1);
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1; busy1 = busy;
    while (!done && lat < 200) begin
      if (poke != 0 && lat == poke) begin
        dividend = 32'h12345678; divisor = 32'h00000003; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0; lat++;
    end
  endtask

  task automatic div_check(input logic [31:0] a, input logic [31:0] b, input string req);
    int lat; logic busy1;
    run_op(a, b, 0, lat, busy1);
    check(done == 1'b1, {req, " done seen"}, 32'(done), 32'd1);
    check(quotient == ref_quot(a, b), req, quotient, ref_quot(a, b));
    check(dbz == 1'b0, {req, " dbz"}, 32'(dbz), 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !dbz, "R1 control outputs", {29'd0, busy, done, dbz}, 32'd0);
    check(quotient == 32'd0, "R1 quotient", quotient, 32'd0);
  endtask

  task automatic t_basic();
    div_check(32'h06000000, 32'h02000000, "R2 6/2");
    div_check(32'h00800000, 32'h04000000, "R2 0.5/4");
    div_check(32'h7F000000, 32'h7F000000, "R2 127/127");
    div_check(32'h00000000, 32'h01000000, "R2 zero dividend");
    div_check(32'h00000001, 32'h01000000, "R2 lsb/1");
  endtask

  task automatic t_signs();
    div_check(32'hF9800000, 32'h02000000, "R3 neg/pos");
    div_check(32'h06800000, 32'hFE000000, "R3 pos/neg");
    div_check(32'hF9800000, 32'hFE000000, "R3 neg/neg");
    div_check(32'h80000000, 32'h02000000, "R3 min/2");
    div_check(32'h01000000, 32'h80000000, "R3 1/min");
  endtask

  task automatic t_trunc();
    int lat; logic busy1;
    run_op(32'h01000000, 32'h03000000, 0, lat, busy1);
    check(quotient == 32'h00555555, "R4 1/3", quotient, 32'h00555555);
    run_op(32'hFF000000, 32'h03000000, 0, lat, busy1);
    check(quotient == 32'hFFAAAAAB, "R4 -1/3", quotient, 32'hFFAAAAAB);
    div_check(32'h00000007, 32'hFD000000, "R4 small/neg");
  endtask

  task automatic t_timing();
    int lat; logic busy1;
    run_op(32'h0A000000, 32'h03000000, 0, lat, busy1);
    check(busy1 == 1'b1, "R5 busy after capture", 32'(busy1), 32'd1);
    check(lat == LAT_RUN, "R5 latency", 32'(lat), 32'(LAT_RUN));
    check(busy == 1'b0, "R5 busy low at done", 32'(busy), 32'd0);
    @(negedge clk);
    check(done == 1'b0, "R5 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic t_busy_ignore();
    int lat; logic busy1;
    run_op(32'h05000000, 32'h02000000, 10, lat, busy1);
    check(quotient == ref_quot(32'h05000000, 32'h02000000), "R6 original result",
          quotient, ref_quot(32'h05000000, 32'h02000000));
    check(lat == LAT_RUN, "R6 latency unchanged", 32'(lat), 32'(LAT_RUN));
    repeat (3) @(negedge clk);
    check(!busy, "R6 no second run", 32'(busy), 32'd0);
  endtask

  task automatic t_divzero();
    int lat; logic busy1;
    run_op(32'h03000000, 32'h00000000, 0, lat, busy1);
    check(lat == LAT_DBZ, "R7 early done", 32'(lat), 32'(LAT_DBZ));
    check(dbz == 1'b1, "R7 flag", 32'(dbz), 32'd1);
    check(quotient == 32'h7FFFFFFF, "R7 positive sat", quotient, 32'h7FFFFFFF);
    run_op(32'hC0000000, 32'h00000000, 0, lat, busy1);
    check(quotient == 32'h80000000, "R7 negative sat", quotient, 32'h80000000);
    run_op(32'h00000000, 32'h00000000, 0, lat, busy1);
    check(quotient == 32'h7FFFFFFF, "R7 zero/zero", quotient, 32'h7FFFFFFF);
  endtask

  task automatic t_wrap();
    div_check(32'h40000000, 32'h00800000, "R8 2^31 wraps");
    div_check(32'h80000000, 32'hFF000000, "R8 min/-1");
    div_check(32'h7F000000, 32'h00000001, "R8 huge wrap");
    div_check(32'h80000000, 32'h00800000, "R8 2^32 wraps");
  endtask

  task automatic t_hold();
    int lat; logic busy1;
    logic [31:0] held;
    run_op(32'h09000000, 32'h00000000, 0, lat, busy1);
    held = quotient;
    repeat (20) @(negedge clk);
    check(quotient == held && dbz, "R9 hold after dbz", quotient, held);
    run_op(32'h09000000, 32'h03000000, 0, lat, busy1);
    check(dbz == 1'b0, "R9 flag cleared by next result", 32'(dbz), 32'd0);
    held = quotient;
    repeat (15) @(negedge clk);
    check(quotient == held, "R9 hold quotient", quotient, held);
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom() >> ($urandom() % 30);
      if ($urandom() % 2) b = ~b + 1'b1;
      if (b == 32'd0) b = 32'd5;
      div_check(a, b, "R2 random");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R5 actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    t_reset();
    t_basic();
    t_signs();
    t_trunc();
    t_timing();
    t_busy_ignore();
    t_divzero();
    t_wrap();
    t_hold();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule